// File: doc/BRIEF.md
# Tagged Multichannel Frame Writer

This block takes complete frames of per-channel samples (eight channels of 24 bits by default) and stores them into a shared memory region through a one-cycle word-write port. Each sample becomes one 32-bit word. The word carries the one-based channel number in its top byte and the sample in its low 24 bits. The words of one frame go out on consecutive cycles at addresses four bytes apart, starting with channel 1.

The region is split into equal blocks (128 KiB by default). A counter of the bytes left in the current block drops by one frame's worth (32 bytes) after each frame. When the counter empties, several things happen together. The counter reloads. A one-cycle host interrupt pulses. The block base moves on by one block, or returns to offset zero when it reaches the region size (1 MiB by default). A programmed number of blocks counts down, and when that number runs out the block stops accepting frames and raises a sticky done flag.

A start pulse arms the block. Before arming, the block checks that the region size presented by the host equals the size it was built for. If the sizes differ, the block enters a halted error state and never writes. A ready/valid handshake holds off the next frame while the eight words of the current one are still being written.

Top module: `frame_tag_writer`

## Requirements
- R1: Each written word holds the sample in bits 23:0 and the channel number (1 for the first channel through 8 for the last) in bits 31:24. Channel k's sample is taken from `frame_data[(k-1)*24 +: 24]`.
- R2: An accepted frame is written as eight words, one per cycle, in channel order 1 to 8, on the eight cycles right after the accepting edge. The address steps by 4 from word to word. The first word's address is `region_base` + block base + bytes already used in the block.
- R3: The bytes-left counter starts at the block size, drops by 32 per frame, and reloads to the block size when a block completes, so the next frame starts at offset 0 of the next block.
- R4: `irq` is high for exactly one cycle, in the cycle after the last word of each completed block, and at no other time.
- R5: The block base advances by the block size at each block end, and returns to 0 when it would reach the region size.
- R6: The block count loaded at start drops by one at each block end. When it reaches zero, `done` rises in the same cycle as that block's `irq` and stays high until reset, and no further frame is accepted. A start with a block count of zero sets `done` at once and nothing is written.
- R7: A start while `region_size` differs from the built-in region size sets `halted` permanently. After that, `frame_ready` and `wr_en` stay low.
- R8: `frame_ready` is high only while armed and not writing a frame. A frame is taken on a clock edge where `frame_valid` and `frame_ready` are both high.
- R9: `start` has no effect once the block has left its idle state.
- R10: After reset, `frame_ready`, `wr_en`, `irq`, `done` and `halted` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm request, honoured only in idle |
| region_size | input | 32 | Region size in bytes, as configured by the host |
| region_base | input | 32 | Byte address of the region start |
| block_count | input | 16 | Number of blocks to record |
| frame_valid | input | 1 | A frame is offered |
| frame_data | input | 192 | Samples, channel 1 in the low 24 bits |
| frame_ready | output | 1 | A frame can be taken |
| wr_en | output | 1 | Word write strobe, accepted in the same cycle |
| wr_addr | output | 32 | Word-aligned byte address |
| wr_data | output | 32 | Tagged sample word |
| irq | output | 1 | One-cycle block-complete pulse |
| done | output | 1 | Sticky: the block count has run out |
| halted | output | 1 | Sticky: region size mismatch at start |

## Verification
The main run uses small block and region sizes so that a recording crosses several block ends and one region wrap. The frames carry all-ones, all-zero, alternating-bit and per-channel-distinct samples: all-ones and all-zero show whether sample bits leak into the tag byte, and the distinct samples show a wrong channel order or a wrong word pick. Frames arrive both back to back and with idle gaps, so the hold-off and the start offset of each write burst are checked under both kinds of arrival. Separate runs start with a wrong region size and with a zero block count, a start pulse is given in the middle of a recording, and frames are offered after done, which checks that nothing is accepted after done or after an error.

// File: rtl/ftw_pkg.sv
package ftw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2,
      ST_HALT = 2'd3
   } ftw_state_t;

endpackage

// File: rtl/ftw_pack.sv
module ftw_pack #(
   parameter int NCH   = 8,
   parameter int SMP_W = 24,
   parameter int TAG_W = 8,
   parameter int IDX_W = 3
) (
   input  logic [NCH*SMP_W-1:0]   frame,
   input  logic [IDX_W-1:0]       sel,
   output logic [TAG_W+SMP_W-1:0] word
);

   localparam int WORD_W = TAG_W + SMP_W;

   logic [WORD_W-1:0] lane [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_lane
      assign lane[c] = {TAG_W'(c + 1), frame[c*SMP_W +: SMP_W]};
   end

   assign word = lane[sel];

endmodule

// File: rtl/ftw_block_track.sv
module ftw_block_track #(
   parameter int AW           = 32,
   parameter int CNT_W        = 16,
   parameter int BLK_BYTES    = 32'h20000,
   parameter int REGION_BYTES = 32'h100000,
   parameter int FRAME_BYTES  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] blocks_in,
   input  logic             frame_fin,
   output logic             run_out,
   output logic [AW-1:0]    offset,
   output logic             irq
);

   localparam logic [AW-1:0] BLK_A    = AW'(BLK_BYTES);
   localparam logic [AW-1:0] REGION_A = AW'(REGION_BYTES);
   localparam logic [AW-1:0] FRAME_A  = AW'(FRAME_BYTES);

   logic [AW-1:0]    rem_q;
   logic [AW-1:0]    base_q;
   logic [CNT_W-1:0] left_q;
   logic             irq_q;
   logic             block_end;
   logic [AW-1:0]    base_nx;

   assign block_end = frame_fin && (rem_q == FRAME_A);
   assign run_out   = block_end && (left_q == CNT_W'(1));
   assign base_nx   = base_q + BLK_A;
   assign offset    = base_q + (BLK_A - rem_q);
   assign irq       = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= BLK_A;
         base_q <= '0;
         left_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (load) begin
            rem_q  <= BLK_A;
            base_q <= '0;
            left_q <= blocks_in;
         end else if (frame_fin) begin
            if (block_end) begin
               rem_q  <= BLK_A;
               irq_q  <= 1'b1;
               left_q <= left_q - CNT_W'(1);
               base_q <= (base_nx == REGION_A) ? '0 : base_nx;
            end else begin
               rem_q <= rem_q - FRAME_A;
            end
         end
      end
   end

   // R4
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R5
   base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_q < REGION_A);

   // R3
   rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q != '0) && (rem_q <= BLK_A));

endmodule

// File: rtl/ftw_seq.sv
module ftw_seq
   import ftw_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int SMP_W = 24,
   parameter int CNT_W = 16,
   parameter int IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 region_ok,
   input  logic [CNT_W-1:0]     blocks_in,
   input  logic                 frame_valid,
   input  logic [NCH*SMP_W-1:0] frame_data,
   input  logic                 run_out,
   output logic                 frame_ready,
   output logic                 load,
   output logic                 frame_fin,
   output logic                 writing,
   output logic [IDX_W-1:0]     idx,
   output logic [NCH*SMP_W-1:0] frame_hold,
   output logic                 done,
   output logic                 halted
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NCH - 1);

   ftw_state_t           state_q;
   logic                 wr_q;
   logic [IDX_W-1:0]     idx_q;
   logic [NCH*SMP_W-1:0] frame_q;
   logic                 accept;

   assign frame_ready = (state_q == ST_RUN) && !wr_q;
   assign accept      = frame_valid && frame_ready;
   assign frame_fin   = wr_q && (idx_q == LAST);
   assign load        = (state_q == ST_IDLE) && start && region_ok
                        && (blocks_in != '0);
   assign writing     = wr_q;
   assign idx         = idx_q;
   assign frame_hold  = frame_q;
   assign done        = (state_q == ST_DONE);
   assign halted      = (state_q == ST_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         idx_q   <= '0;
         frame_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (!region_ok)             state_q <= ST_HALT;
                  else if (blocks_in == '0)   state_q <= ST_DONE;
                  else                        state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (accept) begin
                  frame_q <= frame_data;
                  wr_q    <= 1'b1;
                  idx_q   <= '0;
               end else if (wr_q) begin
                  if (idx_q == LAST) begin
                     wr_q <= 1'b0;
                     if (run_out) state_q <= ST_DONE;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R2
   beat_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_q && (idx_q != LAST)) |=> (wr_q && (idx_q == $past(idx_q) + IDX_W'(1))));

   // R8
   accept_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (wr_q && (idx_q == '0)));

   // R7
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT) |=> ((state_q == ST_HALT) && !wr_q));

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DONE) |=> ((state_q == ST_DONE) && !wr_q));

endmodule

// File: rtl/frame_tag_writer.sv
module frame_tag_writer #(
   parameter int NCH          = 8,
   parameter int SMP_W        = 24,
   parameter int TAG_W        = 8,
   parameter int AW           = 32,
   parameter int CNT_W        = 16,
   parameter int BLK_BYTES    = 32'h20000,
   parameter int REGION_BYTES = 32'h100000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [AW-1:0]          region_size,
   input  logic [AW-1:0]          region_base,
   input  logic [CNT_W-1:0]       block_count,
   input  logic                   frame_valid,
   input  logic [NCH*SMP_W-1:0]   frame_data,
   output logic                   frame_ready,
   output logic                   wr_en,
   output logic [AW-1:0]          wr_addr,
   output logic [TAG_W+SMP_W-1:0] wr_data,
   output logic                   irq,
   output logic                   done,
   output logic                   halted
);

   localparam int WORD_W      = TAG_W + SMP_W;
   localparam int WORD_BYTES  = WORD_W / 8;
   localparam int FRAME_BYTES = NCH * WORD_BYTES;
   localparam int IDX_W       = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 2 || NCH >= (1 << TAG_W)) begin : g_bad_nch
      $error("channel count does not fit the tag field");
   end
   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("word width must be whole bytes");
   end
   if (BLK_BYTES % FRAME_BYTES != 0 || REGION_BYTES % BLK_BYTES != 0) begin : g_bad_geom
      $error("block must hold whole frames and region whole blocks");
   end

   logic                 region_ok;
   logic                 load;
   logic                 frame_fin;
   logic                 run_out;
   logic                 writing;
   logic [IDX_W-1:0]     idx;
   logic [NCH*SMP_W-1:0] frame_hold;
   logic [AW-1:0]        offset;

   assign region_ok = (region_size == AW'(REGION_BYTES));

   ftw_seq #(
      .NCH   (NCH),
      .SMP_W (SMP_W),
      .CNT_W (CNT_W),
      .IDX_W (IDX_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .region_ok   (region_ok),
      .blocks_in   (block_count),
      .frame_valid (frame_valid),
      .frame_data  (frame_data),
      .run_out     (run_out),
      .frame_ready (frame_ready),
      .load        (load),
      .frame_fin   (frame_fin),
      .writing     (writing),
      .idx         (idx),
      .frame_hold  (frame_hold),
      .done        (done),
      .halted      (halted)
   );

   ftw_block_track #(
      .AW           (AW),
      .CNT_W        (CNT_W),
      .BLK_BYTES    (BLK_BYTES),
      .REGION_BYTES (REGION_BYTES),
      .FRAME_BYTES  (FRAME_BYTES)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .blocks_in (block_count),
      .frame_fin (frame_fin),
      .run_out   (run_out),
      .offset    (offset),
      .irq       (irq)
   );

   ftw_pack #(
      .NCH   (NCH),
      .SMP_W (SMP_W),
      .TAG_W (TAG_W),
      .IDX_W (IDX_W)
   ) u_pack (
      .frame (frame_hold),
      .sel   (idx),
      .word  (wr_data)
   );

   assign wr_en   = writing;
   assign wr_addr = region_base + offset + AW'(idx) * AW'(WORD_BYTES);

   // R2
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr[1:0] == region_base[1:0]));

   // R6
   done_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || halted) |-> !frame_ready);

endmodule

// File: tb/frame_tag_writer_bench.sv
module frame_tag_writer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 8;
   localparam int SW         = 24;
   localparam int BLK        = 64;
   localparam int REGION     = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [31:0]       region_size = 32'd0;
   logic [31:0]       region_base = 32'h8000_0000;
   logic [15:0]       block_count = 16'd0;
   logic              frame_valid = 1'b0;
   logic [NCH*SW-1:0] frame_data = '0;
   logic              frame_ready;
   logic              wr_en;
   logic [31:0]       wr_addr;
   logic [31:0]       wr_data;
   logic              irq;
   logic              done;
   logic              halted;

   int checks = 0;
   int bad = 0;
   bit cmp_on = 1'b0;
   int irq_seen = 0;
   int writes_seen = 0;

   // behavioural reference state
   int            m_state = 0;   // 0 idle, 1 armed, 2 done, 3 error
   bit            m_wr = 1'b0;
   int            m_idx = 0;
   int            m_rem = BLK;
   int            m_base = 0;
   int            m_left = 0;
   bit            m_irq = 1'b0;
   logic [SW-1:0] m_smp [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_tag_writer #(
      .BLK_BYTES    (BLK),
      .REGION_BYTES (REGION)
   ) u_frame_tag_writer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .region_size (region_size),
      .region_base (region_base),
      .block_count (block_count),
      .frame_valid (frame_valid),
      .frame_data  (frame_data),
      .frame_ready (frame_ready),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .irq         (irq),
      .done        (done),
      .halted      (halted)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_wr = 0; m_idx = 0; m_rem = BLK;
         m_base = 0; m_left = 0; m_irq = 0;
      end else begin
         m_irq = 0;
         if (m_state == 0) begin
            if (start) begin
               if (region_size != REGION) m_state = 3;
               else if (block_count == 0) m_state = 2;
               else begin
                  m_state = 1; m_left = block_count; m_rem = BLK; m_base = 0;
               end
            end
         end else if (m_state == 1) begin
            if (m_wr) begin
               if (m_idx == NCH - 1) begin
                  m_wr = 0;
                  m_rem = m_rem - NCH * 4;
                  if (m_rem == 0) begin
                     m_irq = 1; m_rem = BLK; m_left = m_left - 1;
                     m_base = m_base + BLK;
                     if (m_base == REGION) m_base = 0;
                     if (m_left == 0) m_state = 2;
                  end
               end else m_idx = m_idx + 1;
            end else if (frame_valid) begin
               for (int c = 0; c < NCH; c++) m_smp[c] = frame_data[c*SW +: SW];
               m_wr = 1; m_idx = 0;
            end
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         // R8
         chk("R8", "frame_ready", {31'd0, frame_ready}, {31'd0, (m_state == 1) && !m_wr});
         // R7 and R2
         chk("R2", "wr_en", {31'd0, wr_en}, {31'd0, m_wr});
         // R4
         chk("R4", "irq", {31'd0, irq}, {31'd0, m_irq});
         // R6
         chk("R6", "done", {31'd0, done}, {31'd0, m_state == 2});
         // R7
         chk("R7", "halted", {31'd0, halted}, {31'd0, m_state == 3});
         if (wr_en && m_wr) begin
            // R2 R3 R5
            chk("R2", "wr_addr", wr_addr,
                region_base + 32'(m_base) + 32'(BLK - m_rem) + 32'(m_idx * 4));
            // R1
            chk("R1", "wr_data", wr_data, {8'(m_idx + 1), m_smp[m_idx]});
         end
         if (irq) irq_seen++;
         if (wr_en) writes_seen++;
      end
   end

   task automatic do_reset();
      cmp_on = 0;
      @(negedge clk);
      rst_n = 0; start = 0; frame_valid = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10
      chk("R10", "reset outputs", {27'd0, frame_ready, wr_en, irq, done, halted}, 32'd0);
      cmp_on = 1;
      irq_seen = 0;
      writes_seen = 0;
   endtask

   task automatic pulse_start();
      start = 1;
      @(negedge clk);
      start = 0;
   endtask

   task automatic send(input logic [NCH*SW-1:0] d, input int max_wait);
      frame_data = d;
      frame_valid = 1;
      for (int w = 0; w < max_wait; w++) begin
         if (frame_ready) begin
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
      frame_valid = 0;
   endtask

   function automatic logic [NCH*SW-1:0] pattern(input int f);
      logic [NCH*SW-1:0] d;
      for (int c = 0; c < NCH; c++) begin
         case (f % 4)
            0: d[c*SW +: SW] = 24'hFFFFFF;
            1: d[c*SW +: SW] = 24'h000000;
            2: d[c*SW +: SW] = (c % 2 == 0) ? 24'hA5A5A5 : 24'h5A5A5A;
            default: d[c*SW +: SW] = 24'(c * 24'h010203 + f * 24'h000101 + 1);
         endcase
      end
      return d;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      // R7: wrong region size
      do_reset();
      region_size = 32'd128; block_count = 16'd3;
      pulse_start();
      send(pattern(3), 5);
      repeat (3) @(negedge clk);
      chk("R7", "halted after mismatch", {31'd0, halted}, 32'd1);
      chk("R7", "no writes while halted", 32'(writes_seen), 32'd0);

      // R6: zero block count
      do_reset();
      region_size = REGION; block_count = 16'd0;
      pulse_start();
      send(pattern(0), 5);
      chk("R6", "done at zero count", {31'd0, done}, 32'd1);
      chk("R6", "no writes at zero count", 32'(writes_seen), 32'd0);

      // main recording: six blocks of two frames, one wrap
      do_reset();
      region_size = REGION; block_count = 16'd6;
      pulse_start();
      for (int f = 0; f < 12; f++) begin
         send(pattern(f), 50);
         if (f == 5) begin
            // R9: start pulse mid-recording ignored
            block_count = 16'd1;
            pulse_start();
         end
         if (f % 3 == 2) repeat (f % 5) @(negedge clk);
      end
      repeat (12) @(negedge clk);
      // R6: frames after done are not taken
      send(pattern(7), 10);
      repeat (3) @(negedge clk);
      chk("R4", "irq pulse count", 32'(irq_seen), 32'd6);
      chk("R2", "total words written", 32'(writes_seen), 32'(12 * NCH));
      chk("R6", "done after last block", {31'd0, done}, 32'd1);
      chk("R9", "recording unaffected by start", {31'd0, halted}, 32'd0);

      cmp_on = 0;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule